// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns bytes written over a small register bus into asynchronous serial characters on a single line. Three format inputs pick the character shape: an 8-bit or 9-bit frame, parity on or off, and even or odd parity. When parity is on, the parity bit takes the place of the highest data bit. So a short frame carries seven data bits plus parity, and a long frame carries eight data bits plus parity. Without parity a long frame carries a ninth data bit, taken from a side input at the moment the byte is written.

A one-byte data buffer sits in front of the shift register. Software writes a byte, and the block moves it into the shifter at the next bit boundary. Two flags report progress: the buffer is empty, and the line has gone quiet. A control byte enables the transmitter, requests break characters and gates the two flags onto one interrupt line. The baud generator is outside the block. It supplies a strobe one clock wide for each bit time.

Top module: `sci_tx`

## Requirements
- R1: After reset, tx_o is 1, tdre_o is 1, tc_o is 1, irq_o is 0 and the control register reads 0x00.
- R2: Each data character begins with one low start bit and ends with one high stop bit, and the data bits go out least significant bit first.
- R3: With fmt_m9_i=0 and fmt_pen_i=0, the character holds the 8 data bits, for 10 bit times in all.
- R4: With fmt_m9_i=1 and fmt_pen_i=0, the character holds the 8 data bits followed by bus_bit8_i, which is captured when the data register is written. The character is 11 bit times.
- R5: With fmt_pen_i=1, a parity bit replaces the top data bit. Frame 0 sends data bits 6..0 and then parity, and frame 1 sends data bits 7..0 and then parity. The character lengths stay 10 and 11 bit times.
- R6: fmt_odd_i=0 selects even parity, so the count of ones in the data and parity bits is even. fmt_odd_i=1 selects odd parity. fmt_odd_i has no effect when fmt_pen_i=0.
- R7: A write with bus_addr_i=0 sets the control register, and a read at that address returns it. Bit 7 enables the buffer-empty interrupt, bit 6 enables the complete interrupt, bit 3 enables the transmitter and bit 0 requests a break. Bits 5, 4, 2 and 1 read back as written. A read with bus_addr_i=1 returns {tdre_o, tc_o, 6'b0}.
- R8: A write with bus_addr_i=1 fills the buffer and clears tdre_o at the next edge. tdre_o sets again at the tick on which the byte moves into the shifter. If a write and a move happen on the same edge, the new byte is kept.
- R9: tc_o is 1 exactly when the shifter is idle and the buffer is empty.
- R10: irq_o = (tdre_o AND ctrl bit 7) OR (tc_o AND ctrl bit 6).
- R11: While ctrl bit 3 is 0, ticks have no effect: the line holds its level, a buffered byte is not taken, and a character already under way pauses.
- R12: While ctrl bit 0 and bit 3 are set, each character slot sends a break in place of any buffered data. The break is low for the full character length of the current format and is followed by one high bit. Buffered data goes out after the break request clears.
- R13: The line changes only at an edge on which baud_tick_i is high, and it moves one bit per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 selects the control register, 1 selects data/status |
| bus_wdata_i | input | 8 | Write data |
| bus_bit8_i | input | 1 | Ninth data bit, captured with a data write |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| fmt_m9_i | input | 1 | 0 selects the 10-bit frame, 1 the 11-bit frame |
| fmt_pen_i | input | 1 | Parity enable |
| fmt_odd_i | input | 1 | 0 selects even parity, 1 odd parity |
| baud_tick_i | input | 1 | One-clock strobe per bit time |
| tx_o | output | 1 | Serial line, idle high |
| tdre_o | output | 1 | Data buffer empty |
| tc_o | output | 1 | Transmission complete |
| irq_o | output | 1 | Interrupt request |

## Verification
Each register write takes effect at the next rising edge: the control readback and tdre_o change one edge after the write, while irq_o and bus_rdata_o follow those registers combinationally. The line, tdre_o on a load, and tc_o change only at an edge where a tick is present, with one bit per tick. The bench keeps its reference model on the same edges and samples every output 1 ns after each rising edge, after the registers have settled and before the inputs change at the falling edge. The tick spacing runs at one, three and five clocks, so a lag of one cycle shows up as a mismatch.

// File: rtl/sci_tx_pkg.sv
package sci_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int BUF_W   = DATA_W + 1;
  localparam int SHIFT_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(SHIFT_W + 1);

  localparam int CTL_TXE_IE = 7;
  localparam int CTL_TC_IE  = 6;
  localparam int CTL_TE     = 3;
  localparam int CTL_SBK    = 0;

  typedef struct packed {
    logic m9;
    logic pen;
    logic odd;
  } fmt_t;

  // payload bits after the start bit, stop bit excluded
  function automatic logic [CNT_W-1:0] payload_len(fmt_t f);
    return f.m9 ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
  endfunction

  function automatic logic [SHIFT_W-1:0] data_frame(fmt_t f, logic [BUF_W-1:0] d);
    logic [BUF_W-1:0] pay;
    logic             p7, p8;
    p7 = (^d[DATA_W-2:0]) ^ f.odd;
    p8 = (^d[DATA_W-1:0]) ^ f.odd;
    if (f.m9) pay = {(f.pen ? p8 : d[DATA_W]), d[DATA_W-1:0]};
    else      pay = {1'b0, (f.pen ? p7 : d[DATA_W-1]), d[DATA_W-2:0]};
    return (SHIFT_W'(pay)) | (SHIFT_W'(1) << payload_len(f));
  endfunction

  function automatic logic [SHIFT_W-1:0] break_frame(fmt_t f);
    return SHIFT_W'(1) << (payload_len(f) + 1'b1);
  endfunction
endpackage

// File: rtl/sci_tx_ctrl.sv
module sci_tx_ctrl
  import sci_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/sci_tx_buf.sv
module sci_tx_buf
  import sci_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit8_i,
  input  logic              take_i,
  output logic [BUF_W-1:0]  data_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (we_i) begin
      data_o <= {bit8_i, wdata_i};
      full_o <= 1'b1;   // write wins over a same-edge take
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end

  a_r8_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> full_o);
endmodule

// File: rtl/sci_tx_shift.sv
module sci_tx_shift
  import sci_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             te_i,
  input  logic             sbk_i,
  input  logic             full_i,
  input  logic [BUF_W-1:0] data_i,
  input  fmt_t             fmt_i,
  output logic             take_o,
  output logic             busy_o,
  output logic             tx_o
);
  logic [SHIFT_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               step, cont;

  assign step   = tick_i & te_i;
  assign cont   = busy_o & (cnt_q != '0);
  assign take_o = step & ~cont & ~sbk_i & full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      tx_o   <= 1'b1;
    end else if (step) begin
      if (cont) begin
        tx_o  <= sh_q[0];
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end else if (sbk_i) begin
        tx_o   <= 1'b0;
        sh_q   <= break_frame(fmt_i);
        cnt_q  <= payload_len(fmt_i) + CNT_W'(2);
        busy_o <= 1'b1;
      end else if (full_i) begin
        tx_o   <= 1'b0;
        sh_q   <= data_frame(fmt_i, data_i);
        cnt_q  <= payload_len(fmt_i) + CNT_W'(1);
        busy_o <= 1'b1;
      end else begin
        tx_o   <= 1'b1;
        busy_o <= 1'b0;
      end
    end
  end

  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !te_i |=> ($stable(tx_o) && $stable(busy_o)));
  a_r13_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tx_o));
endmodule

// File: rtl/sci_tx.sv
module sci_tx
  import sci_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_we_i,
  input  logic       bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  input  logic       bus_bit8_i,
  output logic [7:0] bus_rdata_o,
  input  logic       fmt_m9_i,
  input  logic       fmt_pen_i,
  input  logic       fmt_odd_i,
  input  logic       baud_tick_i,
  output logic       tx_o,
  output logic       tdre_o,
  output logic       tc_o,
  output logic       irq_o
);
  logic [DATA_W-1:0] ctrl;
  logic [BUF_W-1:0]  buf_data;
  logic              buf_full, take, busy;
  fmt_t              fmt;

  assign fmt = '{m9: fmt_m9_i, pen: fmt_pen_i, odd: fmt_odd_i};

  sci_tx_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .we_i    (bus_we_i & ~bus_addr_i),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl)
  );

  sci_tx_buf u_buf (
    .clk_i, .rst_ni,
    .we_i    (bus_we_i & bus_addr_i),
    .wdata_i (bus_wdata_i),
    .bit8_i  (bus_bit8_i),
    .take_i  (take),
    .data_o  (buf_data),
    .full_o  (buf_full)
  );

  sci_tx_shift u_shift (
    .clk_i, .rst_ni,
    .tick_i (baud_tick_i),
    .te_i   (ctrl[CTL_TE]),
    .sbk_i  (ctrl[CTL_SBK]),
    .full_i (buf_full),
    .data_i (buf_data),
    .fmt_i  (fmt),
    .take_o (take),
    .busy_o (busy),
    .tx_o   (tx_o)
  );

  assign tdre_o      = ~buf_full;
  assign tc_o        = ~busy & ~buf_full;
  assign irq_o       = (tdre_o & ctrl[CTL_TXE_IE]) | (tc_o & ctrl[CTL_TC_IE]);
  assign bus_rdata_o = bus_addr_i ? {tdre_o, tc_o, 6'b0} : ctrl;

  a_r9_busy_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !tc_o);
  a_r8_load_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !bus_we_i) |=> tdre_o);
endmodule

// File: tb/sci_tx_bench.sv
module sci_tx_bench;
  logic       clk_i = 0, rst_ni = 0;
  logic       bus_we_i = 0, bus_addr_i = 0, bus_bit8_i = 0;
  logic [7:0] bus_wdata_i = 0;
  logic       fmt_m9_i = 0, fmt_pen_i = 0, fmt_odd_i = 0, baud_tick_i = 0;
  logic [7:0] bus_rdata_o;
  logic       tx_o, tdre_o, tc_o, irq_o;

  sci_tx u_sci_tx (.*);

  always #2 clk_i = ~clk_i;   // 250 MHz

  int    errors = 0, checks = 0, cyc = 0, gap = 3, tcnt = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model
  bit [7:0] m_ctrl;
  bit       m_full, m_busy, m_tx;
  bit [8:0] m_d;
  bit       q[$];

  task automatic push_data();
    int nd, ones;
    ones = 0;
    nd = fmt_m9_i ? 9 : 8;
    if (!fmt_pen_i) begin
      for (int i = 0; i < nd; i++) q.push_back(m_d[i]);
    end else begin
      for (int i = 0; i < nd - 1; i++) begin
        q.push_back(m_d[i]);
        ones += m_d[i];
      end
      q.push_back(bit'(ones % 2) ^ fmt_odd_i);
    end
    q.push_back(1'b1);
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_full = 0; m_busy = 0; m_tx = 1; m_d = 0; q.delete();
    end else begin
      if (baud_tick_i && m_ctrl[3]) begin
        if (m_busy && q.size() > 0) m_tx = q.pop_front();
        else if (m_ctrl[0]) begin
          q.delete();
          for (int i = 0; i < (fmt_m9_i ? 10 : 9); i++) q.push_back(1'b0);
          q.push_back(1'b1);
          m_tx = 0; m_busy = 1;
        end else if (m_full) begin
          q.delete(); push_data();
          m_tx = 0; m_busy = 1; m_full = 0;
        end else begin
          m_tx = 1; m_busy = 0;
        end
      end
      if (bus_we_i && !bus_addr_i) m_ctrl = bus_wdata_i;
      if (bus_we_i && bus_addr_i) begin m_full = 1; m_d = {bus_bit8_i, bus_wdata_i}; end
    end
  end

  task automatic chk(string sig, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h at cycle %0d", cur_req, sig, got, exp, cyc);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    #1;
    if (rst_ni) begin
      bit etdre, etc;
      etdre = !m_full;
      etc = !m_busy && !m_full;
      chk("tx_o (R2 R13)", tx_o, m_tx);
      chk("tdre_o (R8)", tdre_o, etdre);
      chk("tc_o (R9)", tc_o, etc);
      chk("irq_o (R10)", irq_o, (etdre & m_ctrl[7]) | (etc & m_ctrl[6]));
      chk("bus_rdata_o (R7)", bus_rdata_o, bus_addr_i ? {etdre, etc, 6'b0} : m_ctrl);
    end
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    tcnt++;
    baud_tick_i = (tcnt % gap == 0);
  end

  task automatic wr(bit a, bit [7:0] d, bit b8 = 0);
    @(negedge clk_i);
    bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d; bus_bit8_i = b8;
    @(negedge clk_i);
    bus_we_i = 0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((m_busy || m_full) && n < 5000) begin @(negedge clk_i); n++; end
    repeat (gap * 2) @(negedge clk_i);
  endtask

  task automatic send(bit m9, bit pen, bit odd, bit [7:0] d, bit b8 = 0);
    @(negedge clk_i);
    fmt_m9_i = m9; fmt_pen_i = pen; fmt_odd_i = odd;
    wr(1, d, b8);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    checks++;
    if (!(tx_o === 1 && tdre_o === 1 && tc_o === 1 && irq_o === 0 && bus_rdata_o === 8'h00)) begin
      errors++;
      $display("FAIL R1 reset outputs got %b%b%b%b %h exp 1110 00", tx_o, tdre_o, tc_o, irq_o, bus_rdata_o);
    end
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    cur_req = "R7"; wr(0, 8'h08);
    cur_req = "R3"; send(0, 0, 0, 8'hA5); send(0, 0, 1, 8'h3C);
    cur_req = "R4"; send(1, 0, 0, 8'h5A, 1); send(1, 0, 0, 8'hFF, 0);
    cur_req = "R5"; send(0, 1, 0, 8'hB7); send(1, 1, 0, 8'h81);
    cur_req = "R6"; send(0, 1, 1, 8'h07); send(1, 1, 1, 8'h00); send(0, 0, 1, 8'hF0);
    cur_req = "R13"; gap = 1; send(0, 0, 0, 8'h96); gap = 5; send(1, 1, 0, 8'h6D); gap = 3;
    cur_req = "R8";
    wr(1, 8'h11); wr(1, 8'h22); wr(1, 8'h33); drain();
    cur_req = "R10"; wr(0, 8'hC8); send(0, 0, 0, 8'h4E); wr(0, 8'h48); wr(1, 8'h12); drain();
    cur_req = "R11"; wr(0, 8'h00); wr(1, 8'hAA); repeat (30) @(negedge clk_i);
    wr(0, 8'h08); repeat (9) @(negedge clk_i);
    wr(0, 8'h00); repeat (20) @(negedge clk_i); wr(0, 8'h08); drain();
    cur_req = "R12"; wr(1, 8'hC3); wr(0, 8'h09); repeat (80) @(negedge clk_i);
    wr(0, 8'h08); drain();
    fmt_m9_i = 1; wr(0, 8'h09); repeat (40) @(negedge clk_i); wr(0, 8'h08); drain();
    cur_req = "R9"; wr(1, 8'h01); drain();
    cur_req = "R7"; wr(0, 8'hF6); bus_addr_i = 0; repeat (4) @(negedge clk_i);
    wr(0, 8'h00); bus_addr_i = 1; repeat (4) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule